// File: doc/BRIEF.md
# High-Speed Serial Receiver with Flag-Tagged FIFO

This block is the receive path of a fixed-format high-speed serial port. A programmable 8-bit divider produces sample ticks, and fourteen ticks make one bit time. The receiver detects a falling start edge and confirms it at mid-bit, which rejects glitches. It then samples eight data bits, least significant first, and one stop bit at the middle of each bit. Every received character goes into a 64-deep FIFO together with two tags: framing error and break.

Software reaches the block through a small 32-bit register port. Reading the data register pops one character and returns it with its tags and an empty indication. Three conditions raise latched error causes: overrun, break and framing error. Two further causes follow the FIFO state: the fill threshold and the idle-line timeout. Software picks which causes drive the single interrupt output.

Register word addresses on `reg_addr_i`: 0 data, 1 level, 2 status, 3 control, 4 rate.

Top module: `hs_uart_rx`

## Requirements
- R1: The rate register (address 4, bits 7:0) resets to 0xFF. One bit time lasts (rate+1)×14 clock cycles.
- R2: A frame has one low start bit, eight data bits sent LSB first, and a high stop bit. A frame with a valid stop bit is stored with both tags clear.
- R3: A read of address 0 returns the head word: data in bits 7:0, the empty flag in bit 8, the framing-error tag in bit 9 and the break tag in bit 10. A read strobe at address 0 pops the head entry. When the FIFO is empty the read returns 0x100 and the level does not change.
- R4: The level register (address 1, bits 7:0) reports the FIFO fill count. The count runs from 0 to 64.
- R5: Control bits 4:2 select the fill threshold: 0→1, 1→4, 2→8, 3→16, 4→32, and 5 to 7→48 characters. Status bit 1 reads 1 while the level is at or above the threshold.
- R6: Control bits 17:16 select the idle timeout: 0 is off, and 1, 2 and 3 give 4, 8 and 16 character times (140 ticks each). Status bit 2 sets when the line has been idle for that long with data in the FIFO. It clears on any push or pop, and when the FIFO is empty.
- R7: A frame whose stop bit samples low, and which had at least one high data bit, is stored with bit 9 set. It also sets status bit 3.
- R8: A frame that is low through every bit including the stop bit is stored as 0x00 with bit 10 set. It also sets status bit 4. The receiver then waits for the line to go high before it looks for a new start.
- R9: A character that arrives while the FIFO holds 64 entries is dropped and sets status bit 5. The FIFO contents and level stay unchanged.
- R10: Writing 1 to status bits 3, 4 or 5 clears that bit. When a set and a clear happen in the same cycle, the set wins. Writes to status bits 1 and 2 have no effect.
- R11: irq_o is high when control bit 6 is set and status bit 1 or 2 is high. It is also high when control bit 7 is set and any of status bits 3 to 5 is high.
- R12: A low pulse that has ended by the middle of the start bit is rejected. Nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| reg_addr_i | input | 3 | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops at address 0) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt, OR of enabled causes |

## Verification
The checker watches several properties on every cycle:
- the level never passes 64;
- an empty FIFO always presents the 0x100 word;
- a dropped character leaves the level unchanged and sets the overrun latch;
- a write-one clear takes effect unless a new overrun arrives in the same cycle;
- the interrupt never rises while both enables are off.

Some behaviour only the bench scenarios can show: the bit-level deframing at two divider settings, the tagging of framing and break frames, glitch rejection, the threshold boundary between 7 and 8 characters, the timeout window, and FIFO ordering across a full fill.

// File: rtl/hs_rx_pkg.sv
package hs_rx_pkg;
  localparam int DATA_W     = 8;
  localparam int BIT_TICKS  = 14;
  localparam int FRAME_BITS = 10;
  localparam int CHAR_TICKS = BIT_TICKS * FRAME_BITS;

  localparam logic [2:0] ADDR_DATA   = 3'd0;
  localparam logic [2:0] ADDR_LEVEL  = 3'd1;
  localparam logic [2:0] ADDR_STATUS = 3'd2;
  localparam logic [2:0] ADDR_CTRL   = 3'd3;
  localparam logic [2:0] ADDR_RATE   = 3'd4;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic [DATA_W-1:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_STOP,
    FR_WAIT
  } fr_state_e;
endpackage

// File: rtl/hs_rx_baud.sv
module hs_rx_baud #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  // >= keeps the period bounded when rate shrinks mid-count
  assign tick_o = (cnt_q >= rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hs_rx_deframer.sv
module hs_rx_deframer
  import hs_rx_pkg::*;
#(
  parameter int TICKS       = BIT_TICKS,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rx_i,
  output logic     push_o,
  output rx_char_t char_o,
  output logic     idle_o
);
  localparam int CNT_W = $clog2(TICKS);
  localparam int HALF  = TICKS / 2;
  localparam int BIT_W = $clog2(DATA_W);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  fr_state_e              state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [BIT_W-1:0]       bit_q;
  logic [DATA_W-1:0]      shift_q;
  logic                   seen_high_q;
  logic                   push_q;
  rx_char_t               char_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= FR_IDLE;
      cnt_q       <= '0;
      bit_q       <= '0;
      shift_q     <= '0;
      seen_high_q <= 1'b0;
      push_q      <= 1'b0;
      char_q      <= '0;
    end else begin
      push_q <= 1'b0;
      unique case (state_q)
        FR_IDLE: begin
          if (tick_i && !rx_s) begin
            state_q <= FR_START;
            cnt_q   <= '0;
          end
        end
        FR_START: begin
          if (tick_i) begin
            if (cnt_q == CNT_W'(HALF - 1)) begin
              cnt_q       <= '0;
              bit_q       <= '0;
              seen_high_q <= 1'b0;
              state_q     <= rx_s ? FR_IDLE : FR_DATA;  // glitch reject
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        FR_DATA: begin
          if (tick_i) begin
            if (cnt_q == CNT_W'(TICKS - 1)) begin
              cnt_q       <= '0;
              shift_q     <= {rx_s, shift_q[DATA_W-1:1]};
              seen_high_q <= seen_high_q | rx_s;
              bit_q       <= bit_q + 1'b1;
              if (bit_q == BIT_W'(DATA_W - 1)) state_q <= FR_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        FR_STOP: begin
          if (tick_i) begin
            if (cnt_q == CNT_W'(TICKS - 1)) begin
              cnt_q  <= '0;
              push_q <= 1'b1;
              if (rx_s) begin
                char_q  <= '{brk: 1'b0, fe: 1'b0, data: shift_q};
                state_q <= FR_IDLE;
              end else if (!seen_high_q) begin
                char_q  <= '{brk: 1'b1, fe: 1'b0, data: '0};
                state_q <= FR_WAIT;
              end else begin
                char_q  <= '{brk: 1'b0, fe: 1'b1, data: shift_q};
                state_q <= FR_WAIT;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        FR_WAIT: begin
          if (rx_s) state_q <= FR_IDLE;
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end

  assign push_o = push_q;
  assign char_o = char_q;
  assign idle_o = (state_q == FR_IDLE);
endmodule

// File: rtl/hs_rx_fifo.sv
module hs_rx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 10,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign drop_o  = push_i && !do_push;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/hs_uart_rx.sv
module hs_uart_rx
  import hs_rx_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int RATE_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_i,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int CHAR_W  = $bits(rx_char_t);
  localparam int TMO_MAX = 16 * CHAR_TICKS;
  localparam int TMO_W   = $clog2(TMO_MAX + 1);

  logic              tick;
  logic              fr_push, fr_idle;
  rx_char_t          fr_char, head;
  logic [CHAR_W-1:0] head_raw;
  logic [CW-1:0]     fifo_cnt;
  logic              fifo_full, fifo_empty, fifo_drop, fifo_pop;

  logic [RATE_W-1:0] rate_q;
  logic [2:0]        trig_sel_q;
  logic [1:0]        tmo_sel_q;
  logic              rx_en_q, err_en_q;
  logic              fe_q, brk_q, oe_q, tmo_flag_q;
  logic [TMO_W-1:0]  tmo_cnt_q;

  logic st_wr, ctrl_wr, rate_wr;
  logic clr_fe, clr_brk, clr_oe;
  logic trig_hit, tmo_run, tmo_hit;
  logic [31:0] data_word, status_word, ctrl_word;

  hs_rx_baud #(.RATE_W(RATE_W)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rate_i(rate_q),
    .tick_o(tick)
  );

  hs_rx_deframer #(.TICKS(BIT_TICKS), .SYNC_STAGES(2)) u_deframer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .rx_i  (rx_i),
    .push_o(fr_push),
    .char_o(fr_char),
    .idle_o(fr_idle)
  );

  assign fifo_pop = reg_rd_i && (reg_addr_i == ADDR_DATA);

  hs_rx_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (fr_push),
    .wdata_i(fr_char),
    .pop_i  (fifo_pop),
    .rdata_o(head_raw),
    .count_o(fifo_cnt),
    .full_o (fifo_full),
    .empty_o(fifo_empty),
    .drop_o (fifo_drop)
  );
  assign head = rx_char_t'(head_raw);

  function automatic logic [CW-1:0] trig_level(input logic [2:0] sel);
    case (sel)
      3'd0:    return CW'(1);
      3'd1:    return CW'(4);
      3'd2:    return CW'(8);
      3'd3:    return CW'(16);
      3'd4:    return CW'(32);
      default: return CW'(48);
    endcase
  endfunction

  function automatic logic [TMO_W-1:0] tmo_limit(input logic [1:0] sel);
    case (sel)
      2'd1:    return TMO_W'(4 * CHAR_TICKS);
      2'd2:    return TMO_W'(8 * CHAR_TICKS);
      default: return TMO_W'(16 * CHAR_TICKS);
    endcase
  endfunction

  // register writes
  assign st_wr   = reg_wr_i && (reg_addr_i == ADDR_STATUS);
  assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign rate_wr = reg_wr_i && (reg_addr_i == ADDR_RATE);
  assign clr_fe  = st_wr && reg_wdata_i[3];
  assign clr_brk = st_wr && reg_wdata_i[4];
  assign clr_oe  = st_wr && reg_wdata_i[5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q     <= '1;
      trig_sel_q <= '0;
      tmo_sel_q  <= '0;
      rx_en_q    <= 1'b0;
      err_en_q   <= 1'b0;
    end else begin
      if (rate_wr) rate_q <= reg_wdata_i[RATE_W-1:0];
      if (ctrl_wr) begin
        trig_sel_q <= reg_wdata_i[4:2];
        tmo_sel_q  <= reg_wdata_i[17:16];
        rx_en_q    <= reg_wdata_i[6];
        err_en_q   <= reg_wdata_i[7];
      end
    end
  end

  // error latches: set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fe_q  <= 1'b0;
      brk_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      fe_q  <= (fr_push && fr_char.fe)  | (fe_q  & ~clr_fe);
      brk_q <= (fr_push && fr_char.brk) | (brk_q & ~clr_brk);
      oe_q  <= fifo_drop                | (oe_q  & ~clr_oe);
    end
  end

  assign trig_hit = (fifo_cnt >= trig_level(trig_sel_q));

  // idle timeout: counts ticks while line idle and data waits
  assign tmo_run = (tmo_sel_q != 2'd0) && !fifo_empty && fr_idle && !fr_push
                   && !(fifo_pop && !fifo_empty);
  assign tmo_hit = tmo_run && tick && !tmo_flag_q
                   && (tmo_cnt_q == tmo_limit(tmo_sel_q) - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_cnt_q  <= '0;
      tmo_flag_q <= 1'b0;
    end else begin
      if (!tmo_run)                  tmo_cnt_q <= '0;
      else if (tick && !tmo_flag_q)  tmo_cnt_q <= tmo_cnt_q + 1'b1;
      tmo_flag_q <= tmo_hit | (tmo_flag_q & tmo_run);
    end
  end

  // read side
  assign data_word   = fifo_empty ? 32'h0000_0100
                                  : {21'b0, head.brk, head.fe, 1'b0, head.data};
  assign status_word = {26'b0, oe_q, brk_q, fe_q, tmo_flag_q, trig_hit, 1'b0};
  assign ctrl_word   = {14'b0, tmo_sel_q, 8'b0, err_en_q, rx_en_q, 1'b0, trig_sel_q, 2'b0};

  always_comb begin
    case (reg_addr_i)
      ADDR_DATA:   reg_rdata_o = data_word;
      ADDR_LEVEL:  reg_rdata_o = 32'(fifo_cnt);
      ADDR_STATUS: reg_rdata_o = status_word;
      ADDR_CTRL:   reg_rdata_o = ctrl_word;
      ADDR_RATE:   reg_rdata_o = 32'(rate_q);
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_o = (rx_en_q  & (trig_hit | tmo_flag_q))
               | (err_en_q & (fe_q | brk_q | oe_q));

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[31:18], reg_wdata_i[15:8], reg_wdata_i[5],
                          reg_wdata_i[2:0], fifo_full};
endmodule

// File: rtl/hs_rx_checker.sv
module hs_rx_checker #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] level_i,
  input logic [31:0]   data_word_i,
  input logic          drop_i,
  input logic          oe_i,
  input logic          clr_oe_i,
  input logic          rx_en_i,
  input logic          err_en_i,
  input logic          irq_i
);
  assert_level_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= CW'(DEPTH));

  assert_empty_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |-> (data_word_i == 32'h0000_0100));

  assert_drop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> (oe_i && $stable(level_i)));

  assert_oe_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_oe_i && !drop_i) |=> !oe_i);

  assert_irq_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (rx_en_i || err_en_i));
endmodule

bind hs_uart_rx hs_rx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .level_i    (fifo_cnt),
  .data_word_i(data_word),
  .drop_i     (fifo_drop),
  .oe_i       (oe_q),
  .clr_oe_i   (clr_oe),
  .rx_en_i    (rx_en_q),
  .err_en_i   (err_en_q),
  .irq_i      (irq_o)
);

// File: tb/sim_hs_uart_rx.sv
module sim_hs_uart_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hs_uart_rx u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rx_i       (rx),
    .reg_addr_i (addr),
    .reg_wr_i   (wr),
    .reg_rd_i   (rd),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq)
  );

  // {data, stop level, expected data word}
  localparam logic [20:0] VEC [6] = '{
    {8'h55, 1'b1, 12'h055},
    {8'hA3, 1'b1, 12'h0A3},
    {8'h00, 1'b1, 12'h000},
    {8'hFF, 1'b1, 12'h0FF},
    {8'h3C, 1'b0, 12'h23C},
    {8'h00, 1'b0, 12'h400}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic send(input logic [7:0] d, input logic stop, input int bclk);
    @(negedge clk); rx = 1'b0;
    repeat (bclk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (bclk) @(negedge clk);
    end
    rx = stop;
    repeat (bclk) @(negedge clk);
    rx = 1'b1;
    repeat (bclk) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    peek(3'd1, v); chk("R4 reset level", v, 32'h0);
    peek(3'd0, v); chk("R3 reset data word", v, 32'h100);
    peek(3'd2, v); chk("R10 reset status", v, 32'h0);
    peek(3'd4, v); chk("R1 reset rate", v, 32'hFF);
    peek(3'd3, v); chk("R5 reset control", v, 32'h0);
    chk("R11 reset irq", {31'b0, irq}, 32'h0);

    reg_wr(3'd4, 32'h0);

    // vector table
    foreach (VEC[k]) begin
      send(VEC[k][20:13], VEC[k][12], 14);
      peek(3'd1, v); chk("R4 level after frame", v, 32'h1);
      reg_rd(3'd0, v); chk("R2/R7/R8 frame word", v, {20'b0, VEC[k][11:0]});
    end
    peek(3'd2, v); chk("R7/R8 error latches", v, 32'h18);
    reg_wr(3'd2, 32'h1E);
    peek(3'd2, v); chk("R10 write-one clear", v, 32'h0);

    reg_rd(3'd0, v); chk("R3 empty read word", v, 32'h100);
    peek(3'd1, v); chk("R3 empty read keeps level", v, 32'h0);

    // glitch on the line
    @(negedge clk); rx = 1'b0;
    repeat (3) @(negedge clk); rx = 1'b1;
    repeat (200) @(negedge clk);
    peek(3'd1, v); chk("R12 glitch rejected", v, 32'h0);

    // threshold 8 with receive irq
    reg_wr(3'd3, 32'h48);
    for (int i = 0; i < 7; i++) send(8'(8'h10 + i), 1'b1, 14);
    peek(3'd2, v); chk("R5 below threshold", v, 32'h0);
    chk("R11 no irq below threshold", {31'b0, irq}, 32'h0);
    send(8'h17, 1'b1, 14);
    peek(3'd2, v); chk("R5 at threshold", v, 32'h2);
    chk("R11 irq at threshold", {31'b0, irq}, 32'h1);
    reg_wr(3'd2, 32'h06);
    peek(3'd2, v); chk("R10 live bits not cleared", v, 32'h2);
    for (int i = 0; i < 8; i++) begin
      reg_rd(3'd0, v); chk("R2 fifo order", v, 32'(8'h10 + i));
    end
    peek(3'd2, v); chk("R5 drained", v, 32'h0);

    // timeout 4 chars, threshold 32
    reg_wr(3'd3, 32'h10050);
    peek(3'd3, v); chk("R6 control readback", v, 32'h10050);
    send(8'h6B, 1'b1, 14);
    repeat (300) @(negedge clk);
    peek(3'd2, v); chk("R6 before timeout", v, 32'h0);
    repeat (400) @(negedge clk);
    peek(3'd2, v); chk("R6 after timeout", v, 32'h4);
    chk("R11 irq on timeout", {31'b0, irq}, 32'h1);
    reg_rd(3'd0, v); chk("R6 timeout data", v, 32'h6B);
    peek(3'd2, v); chk("R6 cleared by read", v, 32'h0);

    // overrun with error irq only
    reg_wr(3'd3, 32'h80);
    for (int i = 0; i < 65; i++) send(8'(i), 1'b1, 14);
    peek(3'd1, v); chk("R9 level full", v, 32'd64);
    peek(3'd2, v); chk("R9 overrun latched", v, 32'h22);
    chk("R11 irq on overrun", {31'b0, irq}, 32'h1);
    reg_wr(3'd2, 32'h20);
    peek(3'd2, v); chk("R10 overrun cleared", v, 32'h2);
    chk("R11 irq gated off", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 64; i++) begin
      reg_rd(3'd0, v);
      if (i == 0 || i == 63) chk("R9 contents kept", v, 32'(i));
    end
    peek(3'd1, v); chk("R4 drained", v, 32'h0);

    // slower divider
    reg_wr(3'd4, 32'h1);
    peek(3'd4, v); chk("R1 rate readback", v, 32'h1);
    send(8'h96, 1'b1, 28);
    reg_rd(3'd0, v); chk("R1 frame at rate 1", v, 32'h96);

    done = 1'b1;
    summary();
  end
endmodule